// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block is the register core of a general purpose I/O controller. A parameterised number of pins is split into banks of eight lines; line N sits in bank N/8 at bit N%8. Each bank owns two byte-wide registers on a 32-bit register bus: an output-value register and a direction register. Pads are driven through an output-enable and an output value per line. Every pin is also sampled through a two-flop synchronizer so that software can read the level of an input line.

Bank register addresses are not contiguous. A bank's base address is (bank+1)*8, shifted up by 0x10 once that value reaches 0x90. This keeps the 16-byte window at 0x90–0x9F free for the separate interrupt-detection block. Any access that lands in that window is handed over, unchanged, on a one-cycle side port, and the side port's read data is returned on the bus.

A three-state sequencer serves each bus request. IDLE accepts a request and latches it (transition ACCEPT). EXEC decodes the latched address, commits a write or selects the neighbour, and captures read data (transition COMMIT). RESP presents the acknowledge and the read data for one cycle (transition RETIRE back to IDLE).

Top module: `gpio_bank_regfile`

## Requirements
- R1: Bank b answers at base address (b+1)*8, plus 0x10 when that value is 0x90 or more. Line N maps to bank N/8, bit N%8. With the default 150 lines there are 19 banks, and bank 17 sits at 0xA0.
- R2: Bit 2 of the address selects the register inside a bank: 0 selects the output-value register and 1 selects the direction register. Address bits 1:0 are ignored.
- R3: A direction bit of 1 makes the line an input, with pad_oe low. A direction bit of 0 makes it an output, with pad_oe high and pad_out carrying the stored value.
- R4: After reset every direction bit is 1, every stored output value is 0, pad_oe and pad_out are all zero, bus_ready is high and bus_ack is low.
- R5: A read of the output-value register returns, for each input line, the pin level after a two-flop synchronizer. It returns the stored value for each output line. A pin change made just before a request is accepted is therefore not yet visible in that request's read data.
- R6: A write changes a bank register only when bus_be[0] is 1, and it uses only bus_wdata[7:0]. Read data bits 31:8 are zero. Bit positions of the last bank that have no pin read as zero and ignore writes.
- R7: Addresses 0x00–0x07 and addresses of banks at or beyond the bank count read as zero, and writes to them change no pad and no register.
- R8: An access to 0x90–0x9F raises win_sel for exactly the EXEC cycle, with the latched address, write flag, data and strobes. Read data is taken from win_rdata, and no bank register or pad changes.
- R9: A request is accepted on a cycle with bus_req and bus_ready both high. bus_ready is low in the two following cycles, bus_ack is high for exactly the second of them, and bus_ready returns in the cycle after bus_ack.
- R10: pad_oe and pad_out change only in the cycle after a bus_ack. A register write becomes visible on the pads in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, taken when bus_ready is high |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes |
| bus_ready | output | 1 | Sequencer idle, request may be presented |
| bus_ack | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ack (zero for writes) |
| win_sel | output | 1 | Access forwarded to the interrupt-register neighbour |
| win_wr | output | 1 | Forwarded write flag |
| win_addr | output | ADDR_W | Forwarded address |
| win_wdata | output | 32 | Forwarded write data |
| win_be | output | 4 | Forwarded byte strobes |
| win_rdata | input | 32 | Neighbour read data, sampled in the win_sel cycle |
| pad_in | input | NUM_LINES | Asynchronous pin levels |
| pad_oe | output | NUM_LINES | Per-line output enable |
| pad_out | output | NUM_LINES | Per-line output value |

## Verification
The bound checker watches the handshake on every cycle: the fixed accept-to-acknowledge spacing, the single-cycle acknowledge, the neighbour select appearing only inside a busy slot with an address inside the window, and the rule that the pads move only right after an acknowledge. Only the directed scenarios can show the address arithmetic across the window gap, the byte-lane and partial-bank masking, the synchronizer depth, and the mixed input/output readback, because these require expected values computed from a bank map.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned LINES_PER_BANK = 8;
    localparam int unsigned BUS_W          = 32;
    localparam int unsigned BE_W           = BUS_W / 8;

    // Request sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    // What a latched address resolves to
    typedef enum logic [1:0] {
        HIT_NONE = 2'd0,
        HIT_DATA = 2'd1,
        HIT_DIR  = 2'd2,
        HIT_WIN  = 2'd3
    } hit_kind_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_BANKS  = 19,
    parameter int unsigned BANK_IDX_W = 5,
    parameter int unsigned WIN_BASE   = 32'h90,
    parameter int unsigned WIN_SPAN   = 32'h10
) (
    input  logic [ADDR_W-1:2]     word_addr,
    output hit_kind_e             kind,
    output logic [BANK_IDX_W-1:0] bank
);

    localparam int unsigned STRIDE  = LINES_PER_BANK;
    localparam int unsigned WIN_END = WIN_BASE + WIN_SPAN;

    logic [ADDR_W-1:0] base_a;
    int unsigned       base_v;
    int unsigned       slot;

    assign base_a = {word_addr[ADDR_W-1:3], 3'b000};

    always_comb begin
        kind   = HIT_NONE;
        bank   = '0;
        base_v = 32'(base_a);
        slot   = 0;
        if (base_v >= WIN_BASE && base_v < WIN_END) begin
            kind = HIT_WIN;
        end else if (base_v >= STRIDE) begin
            // invert base = (slot+1)*8 (+WIN_SPAN above the window)
            if (base_v >= WIN_END) begin
                slot = (base_v - WIN_SPAN) / STRIDE - 1;
            end else begin
                slot = base_v / STRIDE - 1;
            end
            if (slot < NUM_BANKS) begin
                kind = word_addr[2] ? HIT_DIR : HIT_DATA;
                bank = slot[BANK_IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH = 150
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_line_regs.sv
module gpio_line_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 150,
    parameter int unsigned BANK_IDX_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  hit_kind_e             kind,
    input  logic [BANK_IDX_W-1:0] bank,
    input  logic [7:0]            wbyte,
    output logic [NUM_LINES-1:0]  data_q,
    output logic [NUM_LINES-1:0]  dir_q,
    output logic [NUM_LINES-1:0]  pad_oe,
    output logic [NUM_LINES-1:0]  pad_out
);

    logic [NUM_LINES-1:0] oe_q;
    logic [NUM_LINES-1:0] out_q;

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int unsigned OWNER = l / LINES_PER_BANK;
        localparam int unsigned LANE  = l % LINES_PER_BANK;

        logic hit;
        assign hit = commit && (bank == BANK_IDX_W'(OWNER));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[l] <= 1'b0;
                dir_q[l]  <= 1'b1;
            end else if (hit) begin
                if (kind == HIT_DATA) data_q[l] <= wbyte[LANE];
                if (kind == HIT_DIR)  dir_q[l]  <= wbyte[LANE];
            end
        end
    end

    // Registered pad stage: pads follow the registers one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= '0;
            out_q <= '0;
        end else begin
            oe_q  <= ~dir_q;
            out_q <= data_q;
        end
    end

    assign pad_oe  = oe_q;
    assign pad_out = out_q;

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 150,
    parameter int unsigned NUM_BANKS  = 19,
    parameter int unsigned BANK_IDX_W = 5
) (
    input  hit_kind_e             kind,
    input  logic [BANK_IDX_W-1:0] bank,
    input  logic [NUM_LINES-1:0]  data_q,
    input  logic [NUM_LINES-1:0]  dir_q,
    input  logic [NUM_LINES-1:0]  sync_q,
    input  logic [BUS_W-1:0]      win_rdata,
    output logic [BUS_W-1:0]      rdata
);

    logic [NUM_BANKS-1:0][7:0] val_byte;
    logic [NUM_BANKS-1:0][7:0] dir_byte;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        for (genvar i = 0; i < 8; i++) begin : g_bit
            localparam int unsigned IDX = b * LINES_PER_BANK + i;
            if (IDX < NUM_LINES) begin : g_pin
                assign val_byte[b][i] = dir_q[IDX] ? sync_q[IDX] : data_q[IDX];
                assign dir_byte[b][i] = dir_q[IDX];
            end else begin : g_hole
                assign val_byte[b][i] = 1'b0;
                assign dir_byte[b][i] = 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (kind)
            HIT_DATA: rdata = {24'b0, val_byte[bank]};
            HIT_DIR:  rdata = {24'b0, dir_byte[bank]};
            HIT_WIN:  rdata = win_rdata;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 150,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_BASE  = 32'h90,
    parameter int unsigned WIN_SPAN  = 32'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic [3:0]           bus_be,
    output logic                 bus_ready,
    output logic                 bus_ack,
    output logic [31:0]          bus_rdata,
    output logic                 win_sel,
    output logic                 win_wr,
    output logic [ADDR_W-1:0]    win_addr,
    output logic [31:0]          win_wdata,
    output logic [3:0]           win_be,
    input  logic [31:0]          win_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [NUM_LINES-1:0] pad_out
);

    localparam int unsigned NUM_BANKS  = (NUM_LINES + LINES_PER_BANK - 1) / LINES_PER_BANK;
    localparam int unsigned BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    seq_state_e state_q, state_d;

    logic              req_wr_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [31:0]       req_wdata_q;
    logic [3:0]        req_be_q;
    logic [31:0]       rdata_q;

    hit_kind_e             kind;
    logic [BANK_IDX_W-1:0] bank;
    logic                  commit;
    logic [31:0]           mux_rdata;
    logic [NUM_LINES-1:0]  data_q;
    logic [NUM_LINES-1:0]  dir_q;
    logic [NUM_LINES-1:0]  sync_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, COMMIT, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (bus_req) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the sequencer
    always_comb begin
        bus_ready = 1'b0;
        bus_ack   = 1'b0;
        win_sel   = 1'b0;
        commit    = 1'b0;
        unique case (state_q)
            ST_IDLE: bus_ready = 1'b1;
            ST_EXEC: begin
                win_sel = (kind == HIT_WIN);
                commit  = req_wr_q && req_be_q[0] &&
                          (kind == HIT_DATA || kind == HIT_DIR);
            end
            ST_RESP: bus_ack = 1'b1;
            default: ;
        endcase
    end

    // Request latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_wr_q    <= 1'b0;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_be_q    <= '0;
        end else if (state_q == ST_IDLE && bus_req) begin
            req_wr_q    <= bus_wr;
            req_addr_q  <= bus_addr;
            req_wdata_q <= bus_wdata;
            req_be_q    <= bus_be;
        end
    end

    // Read data capture in EXEC
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == ST_EXEC) begin
            rdata_q <= req_wr_q ? '0 : mux_rdata;
        end
    end

    assign bus_rdata = rdata_q;
    assign win_wr    = req_wr_q;
    assign win_addr  = req_addr_q;
    assign win_wdata = req_wdata_q;
    assign win_be    = req_be_q;

    gpio_addr_decode #(
        .ADDR_W     (ADDR_W),
        .NUM_BANKS  (NUM_BANKS),
        .BANK_IDX_W (BANK_IDX_W),
        .WIN_BASE   (WIN_BASE),
        .WIN_SPAN   (WIN_SPAN)
    ) decode_i (
        .word_addr (req_addr_q[ADDR_W-1:2]),
        .kind      (kind),
        .bank      (bank)
    );

    gpio_in_sync #(
        .WIDTH (NUM_LINES)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_q)
    );

    gpio_line_regs #(
        .NUM_LINES  (NUM_LINES),
        .BANK_IDX_W (BANK_IDX_W)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .kind    (kind),
        .bank    (bank),
        .wbyte   (req_wdata_q[7:0]),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_read_mux #(
        .NUM_LINES  (NUM_LINES),
        .NUM_BANKS  (NUM_BANKS),
        .BANK_IDX_W (BANK_IDX_W)
    ) rmux_i (
        .kind      (kind),
        .bank      (bank),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .sync_q    (sync_q),
        .win_rdata (win_rdata),
        .rdata     (mux_rdata)
    );

endmodule

// File: rtl/gpio_bank_regfile_chk.sv
module gpio_bank_regfile_chk #(
    parameter int unsigned NUM_LINES = 150,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned WIN_BASE  = 32'h90,
    parameter int unsigned WIN_SPAN  = 32'h10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_ready,
    input logic                 bus_ack,
    input logic                 win_sel,
    input logic [ADDR_W-1:0]    win_addr,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic [NUM_LINES-1:0] pad_out
);

    AST_ACCEPT_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ready) |=> (!bus_ready && !bus_ack) ##1 (bus_ack && !bus_ready)); // R9

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> (!bus_ack && bus_ready)); // R9

    AST_WIN_IN_BUSY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> (!bus_ready && !bus_ack)); // R8

    AST_WIN_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |=> bus_ack); // R8

    AST_WIN_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        win_sel |-> (32'(win_addr) >= WIN_BASE && 32'(win_addr) < WIN_BASE + WIN_SPAN)); // R8

    AST_PAD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out != $past(pad_out) || pad_oe != $past(pad_oe)) |-> $past(bus_ack)); // R10

endmodule

bind gpio_bank_regfile gpio_bank_regfile_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W),
    .WIN_BASE  (WIN_BASE),
    .WIN_SPAN  (WIN_SPAN)
) chk_i (.*);

// File: tb/gpio_bank_regfile_tb_top.sv
module gpio_bank_regfile_tb_top;

    localparam int unsigned NL = 150;
    localparam int unsigned AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [3:0]    bus_be = '0;
    logic          bus_ready, bus_ack;
    logic [31:0]   bus_rdata;
    logic          win_sel, win_wr;
    logic [AW-1:0] win_addr;
    logic [31:0]   win_wdata;
    logic [3:0]    win_be;
    logic [31:0]   win_rdata;
    logic [NL-1:0] pad_in = '0;
    logic [NL-1:0] pad_oe, pad_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // recorded per transfer
    logic          r_ready_exec, r_win_sel, r_win_wr, r_ack, r_ready_after, r_ack_after;
    logic [AW-1:0] r_win_addr;
    logic [31:0]   r_win_wdata;
    logic [NL-1:0] r_pad_out_ack, r_pad_oe_ack;

    always #4 clk = ~clk; // 125 MHz

    // neighbour model
    assign win_rdata = {24'hA5A5A5, win_addr};

    gpio_bank_regfile #(.NUM_LINES(NL), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_ready(bus_ready), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .win_sel(win_sel), .win_wr(win_wr), .win_addr(win_addr),
        .win_wdata(win_wdata), .win_be(win_be), .win_rdata(win_rdata),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    function automatic int unsigned base_of(input int unsigned b);
        int unsigned a;
        a = (b + 1) * 8;
        if (a >= 32'h90) a = a + 32'h10;
        return a;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input int unsigned addr, input logic [31:0] wd,
                        input logic [3:0] be, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd; bus_be = be;
        @(posedge clk); #1;
        bus_req = 1'b0;
        r_ready_exec = bus_ready; r_win_sel = win_sel; r_win_wr = win_wr;
        r_win_addr = win_addr; r_win_wdata = win_wdata;
        @(posedge clk); #1;
        r_ack = bus_ack; rd = bus_rdata;
        r_pad_out_ack = pad_out; r_pad_oe_ack = pad_oe;
        @(posedge clk); #1;
        r_ready_after = bus_ready; r_ack_after = bus_ack;
    endtask

    task automatic wr8(input int unsigned addr, input logic [31:0] wd);
        logic [31:0] rd;
        xfer(1'b1, addr, wd, 4'hF, rd);
    endtask

    task automatic rd8(input int unsigned addr, output logic [31:0] rd);
        xfer(1'b0, addr, 32'h0, 4'hF, rd);
    endtask

    task automatic t_reset;
        logic [31:0] rd;
        chk("R4 pad_oe zero", {31'b0, pad_oe == '0}, 32'd1);
        chk("R4 pad_out zero", {31'b0, pad_out == '0}, 32'd1);
        chk("R4 ready", {31'b0, bus_ready}, 32'd1);
        chk("R4 ack low", {31'b0, bus_ack}, 32'd0);
        rd8(base_of(0) + 4, rd);
        chk("R4 dir reset", rd, 32'hFF);
        rd8(base_of(0), rd);
        chk("R4 data reset", rd, 32'h0);
    endtask

    task automatic t_map;
        wr8(base_of(16) + 4, 32'h00);
        wr8(base_of(16), 32'h5A);
        chk("R1 bank16 base", base_of(16), 32'h88);
        chk("R3 bank16 oe", 32'(pad_oe[135:128]), 32'hFF);
        chk("R1 bank16 out", 32'(pad_out[135:128]), 32'h5A);
        wr8(32'hA4, 32'h0F);
        wr8(32'hA0, 32'h33);
        chk("R1 bank17 at 0xA0 oe", 32'(pad_oe[143:136]), 32'hF0);
        chk("R3 bank17 out", 32'(pad_out[143:136]), 32'h33);
        chk("R3 bank0 still input", 32'(pad_oe[7:0]), 32'h00);
    endtask

    task automatic t_window;
        logic [31:0]   rd;
        logic [NL-1:0] so, se;
        so = pad_out; se = pad_oe;
        xfer(1'b1, 32'h94, 32'hDEAD_BEEF, 4'h3, rd);
        chk("R8 win_sel on write", {31'b0, r_win_sel}, 32'd1);
        chk("R8 win addr", 32'(r_win_addr), 32'h94);
        chk("R8 win wr/data", {r_win_wdata[30:0], r_win_wr}, {31'h5EAD_BEEF, 1'b1});
        rd8(32'h98, rd);
        chk("R8 win read data", rd, 32'hA5A5_A598);
        chk("R8 pads untouched", {30'b0, pad_out == so, pad_oe == se}, 32'd3);
        rd8(32'h88, rd);
        chk("R8 win_sel low for bank", {31'b0, r_win_sel}, 32'd0);
    endtask

    task automatic t_sync;
        logic [31:0] rd;
        pad_in[23:16] = 8'hC3;
        repeat (3) @(posedge clk);
        #1;
        rd8(base_of(2), rd);
        chk("R5 input level", rd, 32'hC3);
        pad_in[23:16] = 8'h3C;
        rd8(base_of(2), rd);
        chk("R5 two-flop latency old", rd, 32'hC3);
        rd8(base_of(2), rd);
        chk("R5 new level", rd, 32'h3C);
        pad_in[23:16] = 8'hC3;
        wr8(base_of(2) + 4, 32'h0F);
        wr8(base_of(2), 32'hA5);
        rd8(base_of(2), rd);
        chk("R5 mixed readback", rd, 32'hA3);
    endtask

    task automatic t_strobe;
        logic [31:0] rd;
        logic [31:0] dummy;
        xfer(1'b1, 32'h88, 32'hFFFF_FFFF, 4'hE, dummy);
        rd8(32'h88, rd);
        chk("R6 be0 low ignored", rd, 32'h5A);
        xfer(1'b1, 32'h88, 32'hFFFF_FF3C, 4'h1, dummy);
        rd8(32'h88, rd);
        chk("R6 upper bits zero", rd, 32'h3C);
        rd8(32'h8A, rd);
        chk("R2 low bits ignored data", rd, 32'h3C);
        rd8(32'h8E, rd);
        chk("R2 bit2 selects dir", rd, 32'h00);
        wr8(base_of(18) + 4, 32'h00);
        rd8(base_of(18) + 4, rd);
        chk("R6 partial bank dir", rd, 32'h00);
        chk("R6 partial bank oe", 32'(pad_oe[149:144]), 32'h3F);
        wr8(base_of(18) + 4, 32'hFF);
        rd8(base_of(18) + 4, rd);
        chk("R6 missing bits read zero", rd, 32'h3F);
    endtask

    task automatic t_nobank;
        logic [31:0]   rd;
        logic [NL-1:0] so, se;
        so = pad_out; se = pad_oe;
        wr8(base_of(19) + 4, 32'h00);
        wr8(base_of(19), 32'hFF);
        wr8(32'h04, 32'h00);
        rd8(base_of(19) + 4, rd);
        chk("R7 missing bank reads zero", rd, 32'h0);
        chk("R7 win_sel low", {31'b0, r_win_sel}, 32'd0);
        rd8(32'h04, rd);
        chk("R7 low address reads zero", rd, 32'h0);
        chk("R7 pads untouched", {30'b0, pad_out == so, pad_oe == se}, 32'd3);
        rd8(base_of(0) + 4, rd);
        chk("R7 bank0 dir unchanged", rd, 32'hFF);
    endtask

    task automatic t_timing;
        logic [31:0] rd;
        xfer(1'b1, 32'h88, 32'h96, 4'h1, rd);
        chk("R9 ready low in EXEC", {31'b0, r_ready_exec}, 32'd0);
        chk("R9 ack in RESP", {31'b0, r_ack}, 32'd1);
        chk("R9 ready after ack", {r_ready_after, r_ack_after}, 32'd2);
        chk("R10 pad old during ack", 32'(r_pad_out_ack[135:128]), 32'h3C);
        chk("R10 pad new after ack", 32'(pad_out[135:128]), 32'h96);
        xfer(1'b1, 32'h8C, 32'hF0, 4'h1, rd);
        chk("R10 oe old during ack", 32'(r_pad_oe_ack[135:128]), 32'hFF);
        chk("R10 oe new after ack", 32'(pad_oe[135:128]), 32'h0F);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset;
        t_map;
        t_window;
        t_sync;
        t_strobe;
        t_nobank;
        t_timing;
        done = 1'b1;
        finish_run;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=hung expected=complete");
            finish_run;
        end
    end

endmodule